// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is one register-programmed DMA channel. Software loads a source address, a destination address and a byte length, then writes a control word whose top bit launches the transfer. The engine moves the block one beat at a time over a simple request/grant memory bus: a read beat from the source address, then a write beat of the same data to the destination address. Consecutive beats are grouped into bursts.

Each side of the transfer has its own request-type, address-mode, burst and width fields. A side typed as memory is always ready. Any other type names one line of a request vector, and a burst starts only when that line is high. A side can step its address forward after every beat, or hold it fixed for a peripheral FIFO. While the block is running, the engine raises a half-way pulse and an end pulse. Software can read back how many bytes are still left. Writing the control word with the launch bit clear stops the channel at once. The engine has no chaining, so each block is programmed on its own.

Top module: `dma_chan`

## Requirements
- R1: After reset, the control, source, destination and length registers all read 0. The bus request stays low, and so do both event pulses.
- R2: Register index 0 is control, 1 is source address, 2 is destination address and 3 is length. Writing control with bit 31 set starts a block using the values already held in registers 1 to 3. Control bit 31 reads 1 while the channel is busy and 0 after the end pulse.
- R3: In the control word, the source fields are request type at bits 4:0, fixed-address flag at bit 5, burst at bits 8:7 and width at bits 10:9. The destination fields sit at bits 20:16, 21, 24:23 and 26:25. Burst codes 0/1/2 mean 1/4/8 beats. Width codes 0/1/2 mean 1/2/4 bytes, and bus_size_o carries the width code in use. Each beat uses the narrower of the two widths, and each burst uses the shorter of the two burst lengths. Lengths are multiples of that beat width. Read data is taken from, and write data is placed on, the low byte lanes.
- R4: A side with its fixed-address flag clear steps its address by the beat width after every beat. A side with the flag set uses the same address for every beat.
- R5: Request type 0x16 means memory and is always ready. Any other type t makes that side ready only while drq_i[t] is 1. A burst starts only when both sides are ready. Once started, a burst runs to its end even if the request line drops.
- R6: When fewer bytes remain than a full burst would move, the last burst has only as many beats as are needed to finish the block.
- R7: With control bit 15 set, reading the length register returns the bytes not yet written. With bit 15 clear, it returns the programmed length.
- R8: Exactly one half pulse is raised per nonzero block. It comes on the first beat after which at least floor(length/2) bytes have been written. Exactly one end pulse is raised when the last byte is written.
- R9: Writing control with bit 31 clear halts the channel at once, even partway through a block. No further bus beat or end pulse follows, and the remaining count freezes.
- R10: A block of length 0 produces one end pulse, no half pulse and no bus beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational, from reg_addr_i) |
| drq_i | input | REQ_N | Peripheral request lines, indexed by request type |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr_o | output | ADDR_W | Beat byte address |
| bus_size_o | output | 2 | Beat width code |
| bus_wdata_o | output | 32 | Write data, low lanes |
| bus_rdata_i | input | 32 | Read data, valid in the cycle the grant is given |
| bus_gnt_i | input | 1 | Beat accepted |
| half_o | output | 1 | Half-way pulse |
| end_o | output | 1 | Block end pulse |

## Verification
The hardest state to reach from the ports is a paced burst that keeps running after its request line has dropped and then ends early because the block runs out. The stimulus reaches it with a fixed-address source on a peripheral request line. It pulses that line for a single cycle and counts the write beats until the engine stalls. It then pulses the line again to release the shortened last burst. An abort is fired partway through a long block while the grant is being stalled at random, so the halt lands on a read beat or a write beat without further aiming.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W = 32;
  localparam logic [4:0] MEM_REQ = 5'h16;
  localparam int START_BIT = 31;
  localparam int REMAIN_BIT = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR} st_e;

  typedef struct packed {
    logic [4:0] req;
    logic       fixed;
    logic [1:0] burst;
    logic [1:0] width;
  } side_t;

  function automatic side_t side_of(input logic [REG_W-1:0] cfg, input bit dst);
    side_t s;
    int b;
    b = dst ? 16 : 0;
    s.req   = cfg[b+:5];
    s.fixed = cfg[b+5];
    s.burst = cfg[b+7+:2];
    s.width = cfg[b+9+:2];
    return s;
  endfunction

  function automatic logic [3:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // width code 3 is treated as 4 bytes
  function automatic logic [1:0] width_norm(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dma_cfg_dec.sv
module dma_cfg_dec
  import dma_chan_pkg::*;
(
  input  logic [REG_W-1:0] cfg_i,
  output side_t            src_o,
  output side_t            dst_o,
  output logic [1:0]       size_o,
  output logic [2:0]       bytes_o,
  output logic [3:0]       beats_o
);
  logic [1:0] sw, dw;
  logic [3:0] sb, db;

  always_comb begin
    src_o   = side_of(cfg_i, 1'b0);
    dst_o   = side_of(cfg_i, 1'b1);
    sw      = width_norm(src_o.width);
    dw      = width_norm(dst_o.width);
    sb      = burst_beats(src_o.burst);
    db      = burst_beats(dst_o.burst);
    size_o  = (sw < dw) ? sw : dw;
    bytes_o = 3'd1 << size_o;
    beats_o = (sb < db) ? sb : db;
  end
endmodule

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_chan_pkg::*;
#(
  parameter int REQ_N = 32
) (
  input  logic [4:0]       req_i,
  input  logic [REQ_N-1:0] drq_i,
  output logic             rdy_o
);
  logic [REQ_N-1:0] hit;

  for (genvar g = 0; g < REQ_N; g++) begin : g_line
    assign hit[g] = (req_i == 5'(g)) && drq_i[g];
  end

  assign rdy_o = (req_i == MEM_REQ) || (|hit);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        bytes_i,
  input  logic [3:0]        beats_i,
  input  logic              src_fixed_i,
  input  logic              dst_fixed_i,
  input  logic              src_rdy_i,
  input  logic              dst_rdy_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_gnt_i,
  output logic              half_o,
  output logic              end_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  remain_o
);
  st_e               state;
  logic [CNT_W-1:0]  rem_q, len_q, thr, dec, rem_n;
  logic [ADDR_W-1:0] src_a_q, dst_a_q;
  logic [3:0]        beats_left_q, cap;
  logic [31:0]       data_q;
  logic              half_done_q;
  logic [CNT_W:0]    units;

  always_comb begin
    units = ({1'b0, rem_q} + (CNT_W+1)'(bytes_i) - 1'b1) >> size_i;
    cap   = (units < (CNT_W+1)'(beats_i)) ? units[3:0] : beats_i;
    thr   = len_q - (len_q >> 1);
    dec   = ((CNT_W)'(bytes_i) > rem_q) ? rem_q : (CNT_W)'(bytes_i);
    rem_n = rem_q - dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      rem_q        <= '0;
      len_q        <= '0;
      src_a_q      <= '0;
      dst_a_q      <= '0;
      beats_left_q <= '0;
      data_q       <= '0;
      half_done_q  <= 1'b0;
      half_o       <= 1'b0;
      end_o        <= 1'b0;
    end else begin
      half_o <= 1'b0;
      end_o  <= 1'b0;
      if (load_i) begin
        state       <= ST_ARB;
        rem_q       <= len_i;
        len_q       <= len_i;
        src_a_q     <= src_base_i;
        dst_a_q     <= dst_base_i;
        half_done_q <= 1'b0;
      end else if (abort_i) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ARB: begin
            if (rem_q == '0) begin
              end_o <= 1'b1;
              state <= ST_IDLE;
            end else if (src_rdy_i && dst_rdy_i) begin
              beats_left_q <= cap;
              state        <= ST_RD;
            end
          end
          ST_RD: if (bus_gnt_i) begin
            data_q <= bus_rdata_i;
            state  <= ST_WR;
          end
          ST_WR: if (bus_gnt_i) begin
            rem_q        <= rem_n;
            beats_left_q <= beats_left_q - 1'b1;
            if (!src_fixed_i) src_a_q <= src_a_q + ADDR_W'(bytes_i);
            if (!dst_fixed_i) dst_a_q <= dst_a_q + ADDR_W'(bytes_i);
            if (!half_done_q && rem_n <= thr) begin
              half_o      <= 1'b1;
              half_done_q <= 1'b1;
            end
            if (rem_n == '0) begin
              end_o <= 1'b1;
              state <= ST_IDLE;
            end else if (beats_left_q == 4'd1) begin
              state <= ST_ARB;
            end else begin
              state <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bus_req_o   = (state == ST_RD) || (state == ST_WR);
  assign bus_we_o    = (state == ST_WR);
  assign bus_addr_o  = (state == ST_WR) ? dst_a_q : src_a_q;
  assign bus_size_o  = size_i;
  assign bus_wdata_o = data_q;
  assign busy_o      = (state != ST_IDLE);
  assign remain_o    = rem_q;

  p_burst_needs_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD && $past(state) == ST_ARB && !$past(load_i))
      |-> $past(src_rdy_i && dst_rdy_i));
  p_rem_monotonic_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && !load_i) |=> (rem_q <= $past(rem_q)));
  p_fixed_dst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WR && bus_gnt_i && dst_fixed_i && !load_i && !abort_i)
      |=> (dst_a_q == $past(dst_a_q)));
  p_end_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (state == ST_IDLE));
  p_abort_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state == ST_IDLE && !end_o && !bus_req_o));
  p_beats_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD) |-> (beats_left_q != 4'd0 && beats_left_q <= beats_i));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int REQ_N  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [REQ_N-1:0]  drq_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_gnt_i,
  output logic              half_o,
  output logic              end_o
);
  localparam int CNT_W = REG_W;

  logic [REG_W-1:0]  cfg_q, len_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              cfg_wr, load, abort, busy, src_rdy, dst_rdy;
  side_t             src_s, dst_s;
  logic [1:0]        size;
  logic [2:0]        bytes;
  logic [3:0]        beats;
  logic [CNT_W-1:0]  remain;

  assign cfg_wr = reg_we_i && (reg_addr_i == 2'd0);
  assign load   = cfg_wr && reg_wdata_i[START_BIT];
  assign abort  = cfg_wr && !reg_wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        2'd0: cfg_q <= reg_wdata_i;
        2'd1: src_q <= ADDR_W'(reg_wdata_i);
        2'd2: dst_q <= ADDR_W'(reg_wdata_i);
        default: len_q <= reg_wdata_i;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      2'd0: reg_rdata_o = {busy, cfg_q[REG_W-2:0]};
      2'd1: reg_rdata_o = 32'(src_q);
      2'd2: reg_rdata_o = 32'(dst_q);
      default: reg_rdata_o = cfg_q[REMAIN_BIT] ? remain : len_q;
    endcase
  end

  dma_cfg_dec u_dec (
    .cfg_i  (cfg_q),
    .src_o  (src_s),
    .dst_o  (dst_s),
    .size_o (size),
    .bytes_o(bytes),
    .beats_o(beats)
  );

  dma_req_sel #(.REQ_N(REQ_N)) u_src_sel (.req_i(src_s.req), .drq_i(drq_i), .rdy_o(src_rdy));
  dma_req_sel #(.REQ_N(REQ_N)) u_dst_sel (.req_i(dst_s.req), .drq_i(drq_i), .rdy_o(dst_rdy));

  dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .abort_i    (abort),
    .src_base_i (src_q),
    .dst_base_i (dst_q),
    .len_i      (len_q),
    .size_i     (size),
    .bytes_i    (bytes),
    .beats_i    (beats),
    .src_fixed_i(src_s.fixed),
    .dst_fixed_i(dst_s.fixed),
    .src_rdy_i  (src_rdy),
    .dst_rdy_i  (dst_rdy),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_size_o (bus_size_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .bus_gnt_i  (bus_gnt_i),
    .half_o     (half_o),
    .end_o      (end_o),
    .busy_o     (busy),
    .remain_o   (remain)
  );

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> reg_wdata_i[START_BIT] || busy);
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] drq = 0;
  logic        bus_req, bus_we, bus_gnt = 1, half, endp;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  int checks = 0, errors = 0, cycles = 0;
  int end_cnt = 0, half_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  int half_rem = -1;
  bit gnt_rand = 0;
  logic [7:0] mem [1024];
  logic [7:0] ref_mem [1024];

  always #2 clk = ~clk;

  dma_chan u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .drq_i(drq),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_gnt_i(bus_gnt), .half_o(half), .end_o(endp)
  );

  always_comb
    for (int b = 0; b < 4; b++) bus_rdata[b*8+:8] = mem[(bus_addr[9:0] + 10'(b))];

  always @(negedge clk) begin
    cycles++;
    if (endp) end_cnt++;
    if (half) begin half_cnt++; half_rem = reg_rdata; end
    if (bus_req && bus_gnt && !bus_we) rd_cnt++;
    if (bus_req && bus_gnt && bus_we) begin
      wr_cnt++;
      for (int b = 0; b < (1 << bus_size); b++) mem[bus_addr[9:0] + 10'(b)] = bus_wdata[b*8+:8];
    end
  end

  initial forever begin
    @(posedge clk); #1;
    bus_gnt = gnt_rand ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 2'd3;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1 d = reg_rdata;
    reg_addr = 2'd3;
  endtask

  function automatic logic [31:0] mk_cfg(input int sreq, input bit sfix, input int sb, input int sw,
                                         input int dreq, input bit dfix, input int db, input int dw,
                                         input bit remain);
    logic [31:0] c;
    c = 32'h8000_0000;
    c[4:0] = 5'(sreq); c[5] = sfix; c[8:7] = 2'(sb); c[10:9] = 2'(sw);
    c[20:16] = 5'(dreq); c[21] = dfix; c[24:23] = 2'(db); c[26:25] = 2'(dw);
    c[15] = remain;
    return c;
  endfunction

  function automatic int min_i(input int a, input int b);
    return a < b ? a : b;
  endfunction

  // reference copy, beat by beat
  function automatic void ref_copy(input int src, input int dst, input int len, input int w,
                                   input bit sf, input bit df);
    for (int off = 0; off < len; off += w)
      for (int b = 0; b < w; b++)
        ref_mem[((df ? dst : dst + off) + b) % 1024] = ref_mem[((sf ? src : src + off) + b) % 1024];
  endfunction

  function automatic int exp_half_rem(input int len, input int w);
    int h, mv;
    h = len / 2;
    mv = (h == 0) ? w : ((h + w - 1) / w) * w;
    return len - mv;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'($urandom); ref_mem[i] = mem[i]; end
  endtask

  task automatic compare_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) bad++;
    check(req, bad, 0);
  endtask

  task automatic wait_end(input int limit);
    int e0, n;
    e0 = end_cnt; n = 0;
    while (end_cnt == e0 && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic start(input int src, input int dst, input int len, input logic [31:0] cfg);
    wr_reg(2'd1, 32'(src));
    wr_reg(2'd2, 32'(dst));
    wr_reg(2'd3, 32'(len));
    end_cnt = 0; half_cnt = 0; wr_cnt = 0; rd_cnt = 0; half_rem = -1;
    wr_reg(2'd0, cfg);
  endtask

  initial begin
    logic [31:0] d, rem0;
    int w0;
    void'($urandom(32'd1234));
    fill_mem();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd_reg(2'(a), d); check("R1 reg", d, 0); end
    check("R1 bus_req", bus_req, 0);
    check("R1 pulses", {half, endp}, 0);

    // R3 R4 R8 R7 R2: random memory-to-memory copies with random grant stalls
    gnt_rand = 1;
    for (int it = 0; it < 10; it++) begin
      int sw, dw, sb, db, w, len, src, dst;
      sw = $urandom % 3; dw = $urandom % 3; sb = $urandom % 3; db = $urandom % 3;
      w = 1 << min_i(sw, dw);
      len = w * (1 + $urandom % 40);
      src = 16 + ($urandom % 100) * 4;
      dst = 600 + ($urandom % 50) * 4;
      fill_mem();
      ref_copy(src, dst, len, w, 0, 0);
      start(src, dst, len, mk_cfg(22, 0, sb, sw, 22, 0, db, dw, 1));
      wait_end(5000);
      @(negedge clk);
      compare_mem("R3 R4 copy data");
      check("R3 beat count", wr_cnt, len / w);
      check("R8 end pulses", end_cnt, 1);
      check("R8 half pulses", half_cnt, 1);
      check("R8 remaining at half", half_rem, exp_half_rem(len, w));
      rd_reg(2'd3, d); check("R7 remaining zero", d, 0);
      rd_reg(2'd0, d); check("R2 busy cleared", d[31], 0);
    end
    gnt_rand = 0;

    // R7 length readback with remaining mode off
    fill_mem(); ref_copy(100, 700, 12, 4, 0, 0);
    start(100, 700, 12, mk_cfg(22, 0, 1, 2, 22, 0, 1, 2, 0));
    rd_reg(2'd0, d); check("R2 busy while running", d[31], 1);
    wait_end(2000);
    rd_reg(2'd3, d); check("R7 programmed length", d, 12);
    compare_mem("R3 word copy");

    // R5 R6: paced fixed source, burst 4, length 6 bytes
    fill_mem(); ref_copy(40, 500, 6, 1, 1, 0);
    start(40, 500, 6, mk_cfg(3, 1, 1, 0, 22, 0, 2, 0, 1));
    repeat (20) @(negedge clk);
    check("R5 no beat without request", wr_cnt, 0);
    drq[3] = 1; @(negedge clk); drq[3] = 0;
    repeat (30) @(negedge clk);
    check("R5 burst runs after request drop", wr_cnt, 4);
    rd_reg(2'd3, d); check("R5 remaining while stalled", d, 2);
    drq[3] = 1; @(negedge clk); drq[3] = 0;
    wait_end(200);
    @(negedge clk);
    check("R6 shortened last burst", wr_cnt, 6);
    check("R5 end", end_cnt, 1);
    compare_mem("R4 fixed source data");

    // R4 fixed destination, halfword beats
    fill_mem(); ref_copy(200, 900, 16, 2, 0, 1);
    start(200, 900, 16, mk_cfg(22, 0, 2, 1, 9, 1, 2, 2, 1));
    drq[9] = 1;
    wait_end(2000);
    drq[9] = 0;
    @(negedge clk);
    check("R3 narrower width used", wr_cnt, 8);
    compare_mem("R4 fixed destination data");

    // R9 abort partway through
    gnt_rand = 1;
    fill_mem();
    start(0, 512, 200, mk_cfg(22, 0, 0, 0, 22, 0, 0, 0, 1));
    while (wr_cnt < 7) @(negedge clk);
    wr_reg(2'd0, 32'h0000_8000);
    w0 = wr_cnt + rd_cnt;
    rd_reg(2'd3, rem0);
    repeat (50) @(negedge clk);
    check("R9 no beat after abort", wr_cnt + rd_cnt, w0);
    check("R9 no end pulse", end_cnt, 0);
    rd_reg(2'd3, d); check("R9 remaining frozen", d, rem0);
    rd_reg(2'd0, d); check("R9 busy cleared", d[31], 0);
    check("R9 stopped mid-block", (rem0 > 0 && rem0 < 200) ? 1 : 0, 1);
    gnt_rand = 0;

    // R10 zero length
    start(0, 512, 0, mk_cfg(22, 0, 0, 0, 22, 0, 0, 0, 1));
    wait_end(100);
    repeat (5) @(negedge clk);
    check("R10 end pulse", end_cnt, 1);
    check("R10 no half", half_cnt, 0);
    check("R10 no beats", wr_cnt + rd_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule